// File: doc/BRIEF.md
# Prescaled Triple Interval Timer

This block holds three down-counters that share one base clock. Each counter advances on the strobe of a fixed prescaler. Counter 0 is 16 bits wide and steps once every ten base cycles. Counter 1 is 16 bits wide and steps once every thousand cycles. Counter 2 is 24 bits wide. By default it steps on the slow strobe, but it can instead be clocked by counter 1's terminal pulse or by an external conversion-end or scan-end event. It can also act as a raw event counter or as a watchdog.

Software reaches the block through a small register window with a 3-bit address and a 16-bit data path:

| Address | Register |
|---|---|
| 0 | Gate bits, one per counter at bits 2:0 |
| 1 | Counter modes, a 2-bit field per counter at bit 2·n |
| 2 | Selector: counter select in bits 1:0, general-purpose output nibble in bits 7:4 |
| 3 | Data port, routed to the selected counter |
| 4 | Counter 2 mode: clock source in bits 7:6, role in bits 5:4, interrupt enable at bit 2 |
| 5 | Status: terminal-count flag at bit 12, counter outputs at bits 2:0 |

Counter 2's 24-bit reload is written as two halves through the data port. Its terminal count sets a status flag. That flag can raise an interrupt, and it is cleared by reading the selector.

Each counter runs in one of four behaviours:
- one-shot with a level output
- rate generator
- software-started strobe
- gate-edge-started strobe

In the software-started strobe, writing a reload to counter 0 starts exactly one conversion strobe.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every register reads 0, `dout_o`, `tmr_out_o`, `irq_o` and `wdog_o` are 0, and all counters hold 0.
- R2: Counter 0 steps once every 10 base cycles. Counters 1 and 2 step once every 1000 cycles, for counter 2 when its clock-source field is 0 and its role field is not 1.
- R3: Any reload below 2 is treated as 2.
- R4: A selector write stores bits 1:0 as the select and drives bits 7:4 onto `dout_o` on the next cycle. Selector bits 3:2 read back as 0.
- R5: A data-port read returns the live count without disturbing it. Select 0 and 1 return counters 0 and 1. Select 2 returns counter 2 bits 15:0. Select 3 returns counter 2 bits 23:16 in data bits 7:0.
- R6: A counter whose gate bit is 0 holds its count.
- R7: A data-port write arms a reload that is applied on the counter's next step strobe, even when its gate is 0. Counter 2's reload is written as bits 15:0 with select 2 and bits 23:16 with select 3.
- R8: Mode code 0 (one-shot): the counter stops at 0 after `reload` steps, and its output goes high and stays high until the next reload.
- R9: Mode code 1 (rate generator): on reaching 1 the counter reloads and emits a one-cycle output pulse, so pulses repeat every `reload × divisor` cycles.
- R10: Mode code 2 (software strobe): each reload write gives exactly one one-cycle pulse, `reload` steps after the load, and the counter then stops.
- R11: Mode code 3 (hardware strobe): a reload alone starts nothing. A later 0→1 change of the gate bit starts one countdown that ends in a single pulse.
- R12: Counter 2's terminal count sets status bit 12. `irq_o` is that flag ANDed with mode-register bit 2. Reading the status address leaves the flag set; any read of the selector address clears it.
- R13: Clock-source codes 0, 1, 2 and 3 clock counter 2 from, respectively:
  - the slow strobe
  - counter 1's terminal pulse
  - `conv_end_i`
  - `scan_end_i`
  
  Events on an unselected source are ignored. Role code 1 with source 0 steps counter 2 on every base cycle.
- R14: With role code 2, counter 2's terminal count sets `wdog_o`. It stays set until a mode-register write with a role other than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_rd_i | input | 1 | Read strobe, one cycle (read side effects) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from address |
| conv_end_i | input | 1 | Conversion-end event, one-cycle pulse |
| scan_end_i | input | 1 | Scan-end event, one-cycle pulse |
| dout_o | output | 4 | General-purpose outputs from the selector |
| tmr_out_o | output | 3 | Counter outputs (level in mode code 0, pulse otherwise) |
| irq_o | output | 1 | Counter 2 terminal-count interrupt |
| wdog_o | output | 1 | Watchdog expiry, sticky |

## Verification
The hardest situation to reach from the ports is the gate-edge-started strobe. The reload must land while the gate is low. The bench then has to show that no pulse appears, and only afterwards raise the gate and see exactly one pulse. The stimulus first drops the gate, writes mode code 3 and a reload, and waits through several step strobes before raising the gate. It counts pulses over windows wide enough to catch any extra strobe. The split 24-bit reload is reached the same way: both halves are written with the gate low, and the bench then waits one slow strobe so the frozen count can be read back half by half.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int NUM_TMR   = 3;
  localparam int DIV_FAST  = 10;
  localparam int DIV_SLOW  = 1000;
  localparam int NARROW_W  = 16;
  localparam int WIDE_W    = 24;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 16;
  localparam int MIN_LOAD  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_TMODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_SEL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;

  typedef enum logic [1:0] {
    CM_ONESHOT   = 2'd0,
    CM_RATE      = 2'd1,
    CM_SW_STROBE = 2'd2,
    CM_HW_STROBE = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SRC_OSC  = 2'd0,
    SRC_T1   = 2'd1,
    SRC_CONV = 2'd2,
    SRC_SCAN = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    ROLE_TIMER   = 2'd0,
    ROLE_COUNTER = 2'd1,
    ROLE_WDOG    = 2'd2,
    ROLE_SPARE   = 2'd3
  } role_e;

  function automatic int tmr_width(input int idx);
    return (idx == NUM_TMR - 1) ? WIDE_W : NARROW_W;
  endfunction

  function automatic logic [WIDE_W-1:0] floor_reload(input logic [WIDE_W-1:0] v);
    return (v < WIDE_W'(MIN_LOAD)) ? WIDE_W'(MIN_LOAD) : v;
  endfunction

  function automatic logic [DATA_W-1:0] port_view(
      input logic [1:0]        sel,
      input logic [WIDE_W-1:0] c0,
      input logic [WIDE_W-1:0] c1,
      input logic [WIDE_W-1:0] c2);
    logic [DATA_W-1:0] r;
    unique case (sel)
      2'd0:    r = c0[15:0] | 16'(c0[23:16] & 8'h00);
      2'd1:    r = c1[15:0] | 16'(c1[23:16] & 8'h00);
      2'd2:    r = c2[15:0];
      default: r = {8'h00, c2[23:16]};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  p_tick_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic [1:0]        mode_i,
  input  logic              load_i,
  input  logic [WIDE_W-1:0] reload_i,
  output logic [W-1:0]      cnt_o,
  output logic              tc_o,
  output logic              out_o
);
  logic [W-1:0] cnt_q, reload_eff;
  logic run_q, ld_pend_q, trg_pend_q, gate_q, tc_q, lvl_q;
  logic gate_rise, load_fire, trig_fire, step, at_end;

  always_comb begin
    reload_eff = W'(floor_reload(reload_i));
    gate_rise  = gate_i & ~gate_q;
    load_fire  = tick_i & ld_pend_q;
    trig_fire  = tick_i & ~ld_pend_q & trg_pend_q & (mode_i == CM_HW_STROBE);
    step       = tick_i & ~ld_pend_q & ~trig_fire & gate_i & run_q;
    at_end     = step & (cnt_q == W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      run_q      <= 1'b0;
      ld_pend_q  <= 1'b0;
      trg_pend_q <= 1'b0;
      gate_q     <= 1'b0;
      tc_q       <= 1'b0;
      lvl_q      <= 1'b0;
    end else begin
      gate_q     <= gate_i;
      tc_q       <= at_end;
      ld_pend_q  <= load_i | (ld_pend_q & ~load_fire);
      trg_pend_q <= gate_rise | (trg_pend_q & ~load_fire & ~trig_fire);
      if (load_fire) begin
        cnt_q <= reload_eff;
        run_q <= (mode_i != CM_HW_STROBE);
        lvl_q <= 1'b0;
      end else if (trig_fire) begin
        cnt_q <= reload_eff;
        run_q <= 1'b1;
        lvl_q <= 1'b0;
      end else if (at_end) begin
        if (mode_i == CM_RATE) begin
          cnt_q <= reload_eff;
        end else begin
          cnt_q <= '0;
          run_q <= 1'b0;
          if (mode_i == CM_ONESHOT) lvl_q <= 1'b1;
        end
      end else if (step) begin
        cnt_q <= cnt_q - W'(1);
      end
    end
  end

  assign cnt_o = cnt_q;
  assign tc_o  = tc_q;
  assign out_o = (mode_i == CM_ONESHOT) ? lvl_q : tc_q;

  p_reload_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_fire || trig_fire) |=> (cnt_q >= W'(MIN_LOAD)));
  p_gate_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && !load_fire && !trig_fire) |=> $stable(cnt_q));
  p_pulse_width_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_q |=> !tc_q);
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              conv_end_i,
  input  logic              scan_end_i,
  output logic [3:0]        dout_o,
  output logic [2:0]        tmr_out_o,
  output logic              irq_o,
  output logic              wdog_o
);
  logic [NUM_TMR-1:0]   gate_q;
  logic [2*NUM_TMR-1:0] tmode_q;
  logic [7:0]           sel_q;
  logic [7:0]           mode_q;
  logic [WIDE_W-1:0]    reload_q [NUM_TMR];
  logic                 tc_flag_q, wdog_q;

  logic [WIDE_W-1:0]    cnt_all [NUM_TMR];
  logic [NUM_TMR-1:0]   tc_vec, load_vec;
  logic                 tick_fast, tick_slow, tick_t2;
  logic                 data_wr, mode_wr, sel_rd;
  clk_src_e             src;
  role_e                role;

  assign data_wr = bus_wr_i & (bus_addr_i == A_DATA);
  assign mode_wr = bus_wr_i & (bus_addr_i == A_MODE);
  assign sel_rd  = bus_rd_i & (bus_addr_i == A_SEL);
  assign src     = clk_src_e'(mode_q[7:6]);
  assign role    = role_e'(mode_q[5:4]);

  tmr_prescale #(.DIV(DIV_FAST)) u_pre_fast (.clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick_fast));
  tmr_prescale #(.DIV(DIV_SLOW)) u_pre_slow (.clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick_slow));

  always_comb begin
    unique case (src)
      SRC_OSC:  tick_t2 = (role == ROLE_COUNTER) ? 1'b1 : tick_slow;
      SRC_T1:   tick_t2 = tc_vec[1];
      SRC_CONV: tick_t2 = conv_end_i;
      default:  tick_t2 = scan_end_i;
    endcase
  end

  always_comb begin
    load_vec = '0;
    if (data_wr) begin
      unique case (sel_q[1:0])
        2'd0:    load_vec[0] = 1'b1;
        2'd1:    load_vec[1] = 1'b1;
        default: load_vec[2] = 1'b1;
      endcase
    end
  end

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    localparam int W = tmr_width(gi);
    logic [W-1:0] cnt_w;
    logic         tick_w;
    if (gi == 0) begin : g_fast
      assign tick_w = tick_fast;
    end else if (gi == 1) begin : g_slow
      assign tick_w = tick_slow;
    end else begin : g_sel
      assign tick_w = tick_t2;
    end
    tmr_core #(.W(W)) u_core (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_w),
      .gate_i  (gate_q[gi]),
      .mode_i  (tmode_q[2*gi +: 2]),
      .load_i  (load_vec[gi]),
      .reload_i(reload_q[gi]),
      .cnt_o   (cnt_w),
      .tc_o    (tc_vec[gi]),
      .out_o   (tmr_out_o[gi])
    );
    assign cnt_all[gi] = WIDE_W'(cnt_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q    <= '0;
      tmode_q   <= '0;
      sel_q     <= '0;
      mode_q    <= '0;
      for (int i = 0; i < NUM_TMR; i++) reload_q[i] <= '0;
      tc_flag_q <= 1'b0;
      wdog_q    <= 1'b0;
    end else begin
      if (bus_wr_i) begin
        unique case (bus_addr_i)
          A_CTRL:  gate_q  <= bus_wdata_i[NUM_TMR-1:0];
          A_TMODE: tmode_q <= bus_wdata_i[2*NUM_TMR-1:0];
          A_SEL:   sel_q   <= {bus_wdata_i[7:4], 2'b00, bus_wdata_i[1:0]};
          A_MODE:  mode_q  <= bus_wdata_i[7:0];
          A_DATA: begin
            unique case (sel_q[1:0])
              2'd0:    reload_q[0]        <= {8'h00, bus_wdata_i};
              2'd1:    reload_q[1]        <= {8'h00, bus_wdata_i};
              2'd2:    reload_q[2][15:0]  <= bus_wdata_i;
              default: reload_q[2][23:16] <= bus_wdata_i[7:0];
            endcase
          end
          default: ;
        endcase
      end
      if (tc_vec[2])   tc_flag_q <= 1'b1;
      else if (sel_rd) tc_flag_q <= 1'b0;
      if (tc_vec[2] && role == ROLE_WDOG)                      wdog_q <= 1'b1;
      else if (mode_wr && bus_wdata_i[5:4] != 2'(ROLE_WDOG))   wdog_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr_i)
      A_CTRL:  bus_rdata_o = DATA_W'(gate_q);
      A_TMODE: bus_rdata_o = DATA_W'(tmode_q);
      A_SEL:   bus_rdata_o = DATA_W'(sel_q);
      A_DATA:  bus_rdata_o = port_view(sel_q[1:0], cnt_all[0], cnt_all[1], cnt_all[2]);
      A_MODE:  bus_rdata_o = DATA_W'(mode_q);
      A_STAT:  bus_rdata_o = {3'b000, tc_flag_q, 9'b0, tmr_out_o};
      default: bus_rdata_o = '0;
    endcase
  end

  assign dout_o = sel_q[7:4];
  assign irq_o  = tc_flag_q & mode_q[2];
  assign wdog_o = wdog_q;

  p_dout_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == A_SEL) |=> (dout_o == $past(bus_wdata_i[7:4])));
  p_flag_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_rd && !tc_vec[2]) |=> !tc_flag_q);
  p_flag_set_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_vec[2] |=> tc_flag_q);
  p_wdog_sticky_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_q && !mode_wr) |=> wdog_q);
endmodule

// File: tb/tmr_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        conv_end = 1'b0, scan_end = 1'b0;
  logic [3:0]  dout;
  logic [2:0]  tout;
  logic        irq, wdog;

  int nchk = 0, nerr = 0, cyc = 0;
  int pcount [3] = '{0, 0, 0};
  bit done = 1'b0;
  int tm = 0;

  always #2.5 clk = ~clk;

  tmr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .conv_end_i(conv_end),
    .scan_end_i(scan_end), .dout_o(dout), .tmr_out_o(tout), .irq_o(irq), .wdog_o(wdog)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 3; i++) if (tout[i]) pcount[i] <= pcount[i] + 1;
  end

  function automatic int exp_period(input int reload, input int div);
    return ((reload < 2) ? 2 : reload) * div;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    addr = 3'(a); wdata = 16'(d); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output int d);
    @(negedge clk);
    addr = 3'(a); rd = 1'b1;
    #1 d = int'(rdata);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pulse(input int idx, input int limit, output int t);
    t = -1;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (tout[idx]) begin t = cyc; break; end
    end
  endtask

  task automatic period(input int idx, input int limit, output int p);
    int t1, t2, t3;
    wait_pulse(idx, limit, t1);
    wait_pulse(idx, limit, t2);
    wait_pulse(idx, limit, t3);
    p = (t2 < 0 || t3 < 0) ? -1 : t3 - t2;
  endtask

  task automatic pulse_ev(input bit which, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (which) scan_end = 1'b1; else conv_end = 1'b1;
      @(negedge clk);
      conv_end = 1'b0; scan_end = 1'b0;
      idle(2);
    end
  endtask

  task automatic set_mode(input int t, input int m);
    tm = (tm & ~(3 << (2 * t))) | (m << (2 * t));
    wr_reg(1, tm);
  endtask

  task automatic load(input int sel, input int v);
    wr_reg(2, sel);
    wr_reg(3, v);
  endtask

  initial begin
    int v, a, b, p, snap, r;
    void'($urandom(32'd1234));
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd_reg(5, v); chk("R1 status", v, 0);
    rd_reg(0, v); chk("R1 ctrl", v, 0);
    rd_reg(2, v); chk("R1 selector", v, 0);
    rd_reg(3, v); chk("R1 count0", v, 0);
    chk("R1 outputs", {dout, tout, irq, wdog}, 0);

    // R4 selector and digital outputs
    wr_reg(2, 16'h00A1); chk("R4 dout", dout, 4'hA);
    rd_reg(2, v); chk("R4 sel readback", v, 16'h00A1);
    wr_reg(2, 16'hFFFF); rd_reg(2, v); chk("R4 bits3:2 zero", v, 16'h00F3);
    chk("R4 dout all", dout, 4'hF);

    // R2 R9 counter 0 rate generator
    set_mode(0, 1);
    load(0, 5);
    wr_reg(0, 1);
    period(0, 2000, p); chk("R2 R9 timer0 period", p, exp_period(5, 10));
    // R3 reloads below the minimum
    wr_reg(3, 1); period(0, 2000, p); chk("R3 reload 1", p, exp_period(1, 10));
    wr_reg(3, 0); period(0, 2000, p); chk("R3 reload 0", p, exp_period(0, 10));
    // random reloads
    for (int k = 0; k < 6; k++) begin
      r = int'($urandom_range(40, 2));
      wr_reg(3, r); period(0, 4000, p);
      chk("R9 random period", p, exp_period(r, 10));
    end

    // R2 counter 1 steps every 1000 cycles
    set_mode(1, 1);
    load(1, 3);
    wr_reg(0, 3);
    period(1, 20000, p); chk("R2 timer1 period", p, exp_period(3, 1000));
    wr_reg(0, 1);

    // R5 live read, R6 gate hold
    load(0, 1000);
    idle(50);
    rd_reg(3, a); idle(98); rd_reg(3, b);
    chk("R5 live count decreases", ((a - b) >= 9 && (a - b) <= 11) ? 1 : 0, 1);
    wr_reg(0, 0);
    rd_reg(3, a); idle(200); rd_reg(3, b);
    chk("R6 gate low holds", b, a);

    // R8 one-shot with level output
    set_mode(0, 0);
    wr_reg(3, 4); idle(30);
    chk("R8 out low before gate", tout[0], 0);
    wr_reg(0, 1); idle(100);
    chk("R8 out high", tout[0], 1);
    idle(200);
    chk("R8 out stays high", tout[0], 1);
    rd_reg(3, v); chk("R8 count parked at 0", v, 0);

    // R10 software strobe
    set_mode(0, 2);
    snap = pcount[0];
    wr_reg(3, 3); idle(200);
    chk("R10 one pulse", pcount[0] - snap, 1);
    wr_reg(3, 3); idle(200);
    chk("R10 second pulse", pcount[0] - snap, 2);

    // R11 hardware strobe
    wr_reg(0, 0);
    set_mode(0, 3);
    snap = pcount[0];
    wr_reg(3, 3); idle(200);
    chk("R11 no pulse without gate edge", pcount[0] - snap, 0);
    wr_reg(0, 1); idle(200);
    chk("R11 pulse after gate edge", pcount[0] - snap, 1);
    idle(200);
    chk("R11 single pulse", pcount[0] - snap, 1);

    // R7 split 24-bit reload applied with gate low
    wr_reg(0, 0);
    wr_reg(4, 0);
    load(2, 16'h0005);
    load(3, 16'h0001);
    idle(1100);
    wr_reg(2, 2); rd_reg(3, v); chk("R7 R5 low half", v, 16'h0005);
    wr_reg(2, 3); rd_reg(3, v); chk("R7 R5 high half", v, 16'h0001);

    // R13 counter role on raw clock, R12 flag and interrupt
    wr_reg(4, 16'h0010);
    set_mode(2, 1);
    load(2, 6); load(3, 0);
    wr_reg(0, 4);
    period(2, 200, p); chk("R13 raw clock period", p, 6);
    rd_reg(5, v); chk("R12 flag set", (v >> 12) & 1, 1);
    chk("R12 irq masked", irq, 0);
    wr_reg(4, 16'h0014); idle(2);
    chk("R12 irq enabled", irq, 1);
    wr_reg(0, 0); idle(20);
    rd_reg(5, v); chk("R12 status read keeps flag", (v >> 12) & 1, 1);
    rd_reg(2, v);
    rd_reg(5, v); chk("R12 selector read clears", (v >> 12) & 1, 0);
    chk("R12 irq cleared", irq, 0);

    // R13 conversion-end clock source
    wr_reg(4, 16'h0080);
    load(2, 4); load(3, 0);
    wr_reg(0, 4);
    snap = pcount[2];
    pulse_ev(1'b0, 5); idle(3);
    chk("R13 conv-end clocking", pcount[2] - snap, 1);
    wr_reg(2, 2); rd_reg(3, a);
    pulse_ev(1'b1, 10); idle(3);
    rd_reg(3, b);
    chk("R13 scan-end ignored", b, a);
    chk("R13 no pulse from scan-end", pcount[2] - snap, 1);
    pulse_ev(1'b0, 4); idle(3);
    chk("R13 second pulse", pcount[2] - snap, 2);

    // R14 watchdog role
    wr_reg(0, 0);
    wr_reg(4, 16'h0020);
    set_mode(2, 2);
    load(2, 2); load(3, 0);
    wr_reg(0, 4); idle(10);
    chk("R14 not yet expired", wdog, 0);
    idle(3500);
    chk("R14 expired", wdog, 1);
    idle(1500);
    chk("R14 sticky", wdog, 1);
    wr_reg(4, 16'h0000); idle(1);
    chk("R14 cleared by role change", wdog, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule